// File: doc/BRIEF.md
# Bit-banged serial flash port register

A single memory-mapped control register through which software operates a serial flash device by hand. Three writable bits set the flash clock, chip enable and serial data-in pins directly. Software produces clock edges by writing the clock bit high and then low. Address and data reach the flash only while chip enable is held. The flash serial output is synchronised into the internal clock domain and sampled into a readable bit on every cycle, so a read always returns the latest value.

The register also carries a self-clearing erase trigger. When it is written with 1 while an external two-bit lock field reads 00, the block takes over the pins and runs a fixed erase sequence on its own. The sequence selects the flash, shifts out an 8-bit opcode MSB first and then deselects it. A read-only busy bit covers that sequence, and software writes to the pin bits are dropped while it is set. Only the power-on reset clears the register; a software reset leaves it untouched.

Top module: `flash_bitbang_port`

## Requirements
- R1: Bit 0 is the serial clock. While idle, a write sets `flash_sck` to the written bit 0 from the next clock edge.
- R2: Bit 1 is chip enable and bit 2 is serial data-in. While idle, `flash_ce_n` is the inverse of bit 1 and `flash_si` equals bit 2.
- R3: Read bit 3 returns `flash_so` after a two-flop synchroniser, so it tracks the pin within two clock cycles. Writes to bit 3 have no effect.
- R4: Only `por_n` low clears the register, setting pins to sck 0, ce_n 1, si 0. A pulse on `sw_rst` leaves the stored bits and pins unchanged.
- R5: Read bit 5 is busy. It reads 1 from the clock edge that accepts an erase until the edge that releases chip enable, and `flash_ce_n` is 0 throughout. Writes to bit 5 have no effect.
- R6: A write with bit 4 = 1 starts an erase only when `lock` = 00. With any other lock value busy stays 0. Bit 4 always reads 0.
- R7: An erase lasts 18*HALF_CYC cycles: HALF_CYC with the flash selected and clock low, then 8 bits of ERASE_OP (default 8'hC7) MSB first, each with HALF_CYC clock-low and HALF_CYC clock-high cycles and data stable across the rising edge, then HALF_CYC with clock low before release.
- R8: While busy, writes to bits 0 to 2 and to the erase bit are ignored.
- R9: Bits 6 and above always read 0.
- R10: When an erase ends, the pins return to the values held in bits 0 to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset of the host; has no effect on this register |
| wr_en | input | 1 | Register write strobe |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data |
| lock | input | 2 | External access-control field; 00 permits erase |
| flash_sck | output | 1 | Flash serial clock |
| flash_ce_n | output | 1 | Flash chip select, active low |
| flash_si | output | 1 | Serial data to the flash |
| flash_so | input | 1 | Serial data from the flash |

## Verification
On every cycle the assertions check the following: the clock pin follows an idle write; the erase start depends on the lock field; stored pin bits are frozen during busy and across software reset; and chip enable stays asserted for the whole busy window. Only the bench scenarios can show the exact sequence length, the opcode bits reassembled from clock rising edges, and the return of the pins to the software values afterwards. They also show the synchroniser delay on bit 3 and the full clear by power-on reset.

// File: rtl/flash_bitbang_port.sv
module flash_bitbang_port #(
  parameter int          DATA_W      = 32,
  parameter int          HALF_CYC    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  ERASE_OP    = 8'hC7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [1:0]        lock,
  output logic              flash_sck,
  output logic              flash_ce_n,
  output logic              flash_si,
  input  logic              flash_so
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int B_SCK = 0;
  localparam int B_CE  = 1;
  localparam int B_SI  = 2;
  localparam int B_SO  = 3;
  localparam int B_ERS = 4;
  localparam int B_BSY = 5;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_LO, S_HI, S_END} seq_t;

  logic [2:0]             ctl_q;
  logic [SYNC_STAGES-1:0] so_pipe;
  seq_t                   st;
  logic [CNT_W-1:0]       tick;
  logic [2:0]             bit_idx;
  logic                   busy, last_tick, erase_go, shifting;

  assign busy      = (st != S_IDLE);
  assign last_tick = (tick == CNT_W'(HALF_CYC - 1));
  assign erase_go  = wr_en && wdata[B_ERS] && (lock == 2'b00) && !busy;
  assign shifting  = (st == S_LO) || (st == S_HI);

  wire unused_bits = ^{wdata[DATA_W-1:B_SO+1] & {(DATA_W-B_SO-1){1'b0}}, wdata[B_SO], sw_rst};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)               ctl_q <= '0;
    else if (wr_en && !busy)  ctl_q <= {wdata[B_SI], wdata[B_CE], wdata[B_SCK]};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) so_pipe <= '0;
    else        so_pipe <= {so_pipe[SYNC_STAGES-2:0], flash_so};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= S_IDLE;
      tick    <= '0;
      bit_idx <= 3'd7;
    end else if (st == S_IDLE) begin
      if (erase_go) begin
        st      <= S_SEL;
        tick    <= '0;
        bit_idx <= 3'd7;
      end
    end else if (last_tick) begin
      tick <= '0;
      case (st)
        S_SEL: st <= S_LO;
        S_LO:  st <= S_HI;
        S_HI: begin
          if (bit_idx == 3'd0) st <= S_END;
          else begin
            bit_idx <= bit_idx - 3'd1;
            st      <= S_LO;
          end
        end
        default: st <= S_IDLE;
      endcase
    end else begin
      tick <= tick + CNT_W'(1);
    end
  end

  assign flash_sck  = busy ? (st == S_HI) : ctl_q[0];
  assign flash_ce_n = busy ? 1'b0 : ~ctl_q[1];
  assign flash_si   = shifting ? ERASE_OP[bit_idx] : (busy ? 1'b0 : ctl_q[2]);

  always_comb begin
    rdata        = '0;
    rdata[B_SCK] = ctl_q[0];
    rdata[B_CE]  = ctl_q[1];
    rdata[B_SI]  = ctl_q[2];
    rdata[B_SO]  = so_pipe[SYNC_STAGES-1];
    rdata[B_BSY] = busy;
  end

  p_sck_write_r1: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !busy && !(wdata[B_ERS] && lock == 2'b00)) |=> (flash_sck == $past(wdata[B_SCK])));

  p_swrst_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    (sw_rst && !wr_en) |=> $stable(rdata[2:0]));

  p_busy_selects_r5: assert property (@(posedge clk) disable iff (!por_n)
    rdata[B_BSY] |-> !flash_ce_n);

  p_erase_start_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[B_ERS] && lock == 2'b00 && !rdata[B_BSY]) |=> (rdata[B_BSY] && !flash_ce_n));

  p_locked_no_erase_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wdata[B_ERS] && lock != 2'b00 && !rdata[B_BSY]) |=> !rdata[B_BSY]);

  p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!por_n)
    (rdata[B_BSY] && wr_en) |=> $stable(rdata[2:0]));
endmodule

// File: tb/test_flash_bitbang_port.sv
module test_flash_bitbang_port;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int HALF_CYC   = 4;
  localparam int NV         = 8;

  logic clk = 1'b0, por_n = 1'b0, sw_rst = 1'b0, wr_en = 1'b0, flash_so = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [1:0] lock = 2'b00;
  logic flash_sck, flash_ce_n, flash_si;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bitbang_port #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) i_flash_bitbang_port (
    .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .lock(lock), .flash_sck(flash_sck), .flash_ce_n(flash_ce_n),
    .flash_si(flash_si), .flash_so(flash_so));

  // {lock[1:0], so, wbits[5:0], exp_rd[5:0], exp_pins{sck,ce_n,si}}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 1'b0, 6'b000001, 6'b000001, 3'b110},
    {2'b00, 1'b1, 6'b000010, 6'b001010, 3'b000},
    {2'b00, 1'b0, 6'b000111, 6'b000111, 3'b101},
    {2'b00, 1'b0, 6'b101000, 6'b000000, 3'b010},
    {2'b01, 1'b0, 6'b010011, 6'b000011, 3'b100},
    {2'b10, 1'b1, 6'b010101, 6'b001101, 3'b111},
    {2'b11, 1'b0, 6'b010110, 6'b000110, 3'b001},
    {2'b00, 1'b1, 6'b000000, 6'b001000, 3'b010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset rdata", rdata, 32'h0);
    chk("R4 reset pins", {29'd0, flash_sck, flash_ce_n, flash_si}, 32'b010);
    por_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      lock     = VEC[v][17:16];
      flash_so = VEC[v][15];
      wdata    = {26'd0, VEC[v][14:9]};
      wr_en    = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 R2 R3 R6 vector rdata", {26'd0, rdata[5:0]}, {26'd0, VEC[v][8:3]});
      chk("R1 R2 vector pins", {29'd0, flash_sck, flash_ce_n, flash_si}, {29'd0, VEC[v][2:0]});
    end
    lock = 2'b00;
    flash_so = 1'b0;

    wdata = 32'hFFFF_FFC0; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; repeat (2) @(negedge clk);
    chk("R9 upper bits read zero", rdata, 32'h0);

    wdata = 32'h05; wr_en = 1'b1;
    @(negedge clk);
    wdata = 32'h15;
    @(negedge clk);
    wr_en = 1'b0;
    begin
      int cnt = 0;
      logic [7:0] op = '0;
      logic prev_sck = 1'b0;
      bit ce_ok = 1'b1;
      while (rdata[5] && cnt < 1000) begin
        cnt++;
        if (flash_ce_n !== 1'b0) ce_ok = 1'b0;
        if (!prev_sck && flash_sck) op = {op[6:0], flash_si};
        prev_sck = flash_sck;
        if (cnt == 5) begin wdata = 32'h12; wr_en = 1'b1; end
        if (cnt == 6) wr_en = 1'b0;
        @(negedge clk);
      end
      chk("R5 R7 busy length", cnt, 18 * HALF_CYC);
      chk("R7 opcode shifted MSB first", {24'd0, op}, 32'hC7);
      chk("R5 ce held during busy", {31'd0, ce_ok}, 32'd1);
    end
    repeat (3) @(negedge clk);
    chk("R8 erase write while busy ignored", {31'd0, rdata[5]}, 32'd0);
    chk("R8 pin bits kept across busy", {29'd0, rdata[2:0]}, 32'b101);
    chk("R10 pins restored after erase", {29'd0, flash_sck, flash_ce_n, flash_si}, 32'b111);

    sw_rst = 1'b1;
    repeat (3) @(negedge clk);
    sw_rst = 1'b0;
    @(negedge clk);
    chk("R4 soft reset keeps bits", {29'd0, rdata[2:0]}, 32'b101);

    flash_so = 1'b1;
    @(negedge clk);
    chk("R3 not yet through synchroniser", {31'd0, rdata[3]}, 32'd0);
    @(negedge clk);
    chk("R3 sample after two cycles", {31'd0, rdata[3]}, 32'd1);

    por_n = 1'b0;
    @(negedge clk);
    chk("R4 power-on reset clears", rdata, 32'h0);
    chk("R4 power-on reset pins", {29'd0, flash_sck, flash_ce_n, flash_si}, 32'b010);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule